// File: doc/BRIEF.md
# Refresh Scheduler with CAS-Leading Refresh Order

This block keeps an asynchronous DRAM refreshed on behalf of a main memory controller. After reset it holds the DRAM control pins itself, waits out a power-up pause, and then issues a fixed burst of refresh cycles. Only after that burst does it raise `ready` to allow normal traffic. From then on a free-running interval timer produces one refresh opportunity per interval. Each opportunity adds one to a small saturating count of owed refreshes.

While refreshes are owed, the block asks the main controller for the pins with `ref_req`. It waits for `ref_gnt` and then takes the pins through an owner-select multiplexer. It performs every owed refresh back to back and hands the pins back with a one-cycle `ref_done` pulse. Each refresh drops column strobe first and then row strobe, so the DRAM refreshes the row chosen by its own internal counter. Write enable stays high for the whole refresh. The pause, the burst length, the interval and every strobe width are counted in clock cycles and set by parameters.

The request and grant pins are plain control signals, not a data stream. `ref_req` stays high until a grant is sampled. A grant sampled while `ref_req` is low has no effect. There is no back-pressure after the grant: the refresh sequence runs to completion.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is active, and for PAUSE_CYC cycles after it is released, the block owns the pins and holds row strobe, column strobe and write enable high. Column strobe first goes low in cycle PAUSE_CYC after release, counting the first active edge as cycle 1.
- R2: Before `ready` rises, exactly INIT_CYCLES refresh cycles are performed and `ref_req` stays low. `ready` rises after the last precharge of that burst.
- R3: In every refresh, column strobe is low, with row strobe high, for exactly CSR_CYC cycles before row strobe falls. Column strobe then stays low for as long as row strobe is low.
- R4: Row strobe stays low for exactly RAS_CYC cycles in each refresh, and is then held high for RP_CYC cycles before the next column-strobe fall or before `ref_done`.
- R5: Write enable is high in every cycle in which the block owns the pins.
- R6: The timer starts counting when `ready` rises and produces one owed refresh every INTERVAL_CYC cycles. A `ref_req` rising edge is seen 1 + k·INTERVAL_CYC cycles after `ready` rises, for some whole number k ≥ 1. The first one is seen INTERVAL_CYC+1 cycles after `ready` rises.
- R7: `ref_req` stays high until `ref_gnt` is sampled high. In the cycle after that sample, the block owns the pins and `ref_req` is low.
- R8: In one grant, the block performs one refresh for each refresh owed at the time of the grant, back to back, and then releases the pins.
- R9: The owed count saturates at DEBT_MAX. Opportunities that arrive while the count is full are lost.
- R10: `ref_done` is a one-cycle pulse. It is raised in the first cycle after the final precharge, with the pins already returned to the main controller.
- R11: While the block does not own the pins, the DRAM pins copy the main controller's strobes. While it owns them, those inputs have no effect.
- R12: After a grant, the block holds all strobes high for RP_CYC cycles before the first column-strobe fall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mc_ras_n | input | 1 | Row strobe from the main controller |
| mc_cas_n | input | 1 | Column strobe from the main controller |
| mc_we_n | input | 1 | Write enable from the main controller |
| ref_gnt | input | 1 | Grant of the pins to the refresher |
| ref_req | output | 1 | Refresh wanted; held until granted |
| ref_done | output | 1 | One-cycle pulse when the pins are returned |
| ref_owner | output | 1 | High while the refresher drives the pins |
| ready | output | 1 | Initialisation finished |
| dram_ras_n | output | 1 | Row strobe to the DRAM |
| dram_cas_n | output | 1 | Column strobe to the DRAM |
| dram_we_n | output | 1 | Write enable to the DRAM |

## Verification
The assertions assume the main controller leaves its strobes high when it grants the pins, and that it raises `ref_gnt` only while `ref_req` is high. Under those assumptions, any strobe edge seen while the refresher owned the pins in both cycles was made by the refresher. The stimulus grants only in answer to a pending request, and it keeps each grant's burst shorter than one interval, so no new opportunity arrives during a burst. The bench drives a changing pattern on the controller strobes throughout the run, so the multiplexer is tested in both directions.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_IDLE,
    ST_REQ,
    ST_LEAD,
    ST_CAS,
    ST_RAS,
    ST_PRE
  } rs_state_e;

  // pin vector positions
  localparam int PIN_RAS = 0;
  localparam int PIN_CAS = 1;
  localparam int PIN_WE  = 2;
  localparam int NPINS   = 3;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
  parameter int INTERVAL_CYC = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int TW = (INTERVAL_CYC > 2) ? $clog2(INTERVAL_CYC) : 1;
  localparam logic [TW-1:0] LAST = TW'(INTERVAL_CYC - 1);

  logic [TW-1:0] t_q;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) t_q <= '0;
    else if (t_q == LAST) t_q <= '0;
    else t_q <= t_q + 1'b1;
  end

  assign tick = run && (t_q == LAST);
endmodule

// File: rtl/ref_debt_ctr.sv
module ref_debt_ctr #(
  parameter int DEBT_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic add,
  input  logic take,
  output logic owed_nz
);
  localparam int DW = $clog2(DEBT_MAX + 1);
  localparam logic [DW-1:0] FULL = DW'(DEBT_MAX);

  logic [DW-1:0] owed_q;
  logic          add_ok;

  // a new opportunity counts when there is room, or when one leaves in the same cycle
  assign add_ok = add && ((owed_q != FULL) || take);

  always_ff @(posedge clk) begin
    if (!rst_n) owed_q <= '0;
    else begin
      case ({add_ok, take})
        2'b10:   owed_q <= owed_q + 1'b1;
        2'b01:   owed_q <= owed_q - 1'b1;
        default: owed_q <= owed_q;
      endcase
    end
  end

  assign owed_nz = (owed_q != '0);
endmodule

// File: rtl/ref_cycle_fsm.sv
module ref_cycle_fsm
  import refsched_pkg::*;
#(
  parameter int PAUSE_CYC   = 10000,
  parameter int INIT_CYCLES = 8,
  parameter int CSR_CYC     = 1,
  parameter int RAS_CYC     = 6,
  parameter int RP_CYC      = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             owed_nz,
  input  logic             gnt,
  output logic             take,
  output logic             req,
  output logic             done,
  output logic             owner,
  output logic             ready,
  output logic [NPINS-1:0] pins_n
);
  localparam int MAXD = max4(PAUSE_CYC, CSR_CYC, RAS_CYC, RP_CYC);
  localparam int CW   = $clog2(MAXD + 1);
  localparam int IW   = $clog2(INIT_CYCLES + 1);
  localparam logic [CW-1:0] L_PAUSE = CW'(PAUSE_CYC - 1);
  localparam logic [CW-1:0] L_CSR   = CW'(CSR_CYC - 1);
  localparam logic [CW-1:0] L_RAS   = CW'(RAS_CYC - 1);
  localparam logic [CW-1:0] L_RP    = CW'(RP_CYC - 1);

  rs_state_e     st_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] init_left_q;
  logic          ready_q, done_q;
  logic          expire;

  assign expire = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_PAUSE;
      cnt_q       <= L_PAUSE;
      init_left_q <= IW'(INIT_CYCLES);
      ready_q     <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!expire) cnt_q <= cnt_q - 1'b1;
      case (st_q)
        ST_PAUSE: if (expire) begin st_q <= ST_CAS; cnt_q <= L_CSR; end
        ST_IDLE:  if (ready_q && owed_nz) st_q <= ST_REQ;
        ST_REQ:   if (gnt) begin st_q <= ST_LEAD; cnt_q <= L_RP; end
        ST_LEAD:  if (expire) begin st_q <= ST_CAS; cnt_q <= L_CSR; end
        ST_CAS:   if (expire) begin st_q <= ST_RAS; cnt_q <= L_RAS; end
        ST_RAS: if (expire) begin
          st_q  <= ST_PRE;
          cnt_q <= L_RP;
          if (!ready_q) init_left_q <= init_left_q - 1'b1;
        end
        ST_PRE: if (expire) begin
          if (!ready_q) begin
            if (init_left_q == '0) begin ready_q <= 1'b1; st_q <= ST_IDLE; end
            else begin st_q <= ST_CAS; cnt_q <= L_CSR; end
          end else if (owed_nz) begin
            st_q <= ST_CAS; cnt_q <= L_CSR;
          end else begin
            done_q <= 1'b1; st_q <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign take  = ready_q && (st_q == ST_RAS) && expire;
  assign req   = (st_q == ST_REQ);
  assign done  = done_q;
  assign ready = ready_q;
  assign owner = (st_q != ST_IDLE) && (st_q != ST_REQ);

  always_comb begin
    pins_n          = '1;
    pins_n[PIN_RAS] = (st_q != ST_RAS);
    pins_n[PIN_CAS] = !((st_q == ST_CAS) || (st_q == ST_RAS));
    pins_n[PIN_WE]  = 1'b1;
  end
endmodule

// File: rtl/ref_pin_mux.sv
module ref_pin_mux #(
  parameter int N = 3
) (
  input  logic         sel_ref,
  input  logic [N-1:0] ref_n,
  input  logic [N-1:0] mc_n,
  output logic [N-1:0] out_n
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    assign out_n[i] = sel_ref ? ref_n[i] : mc_n[i];
  end
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
  import refsched_pkg::*;
#(
  parameter int PAUSE_CYC    = 10000,
  parameter int INIT_CYCLES  = 8,
  parameter int INTERVAL_CYC = 1560,
  parameter int CSR_CYC      = 1,
  parameter int RAS_CYC      = 6,
  parameter int RP_CYC       = 4,
  parameter int DEBT_MAX     = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mc_ras_n,
  input  logic mc_cas_n,
  input  logic mc_we_n,
  input  logic ref_gnt,
  output logic ref_req,
  output logic ref_done,
  output logic ref_owner,
  output logic ready,
  output logic dram_ras_n,
  output logic dram_cas_n,
  output logic dram_we_n
);
  logic             tick, take, owed_nz;
  logic [NPINS-1:0] ref_pins_n, mc_pins_n, out_pins_n;

  ref_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(ready), .tick(tick)
  );

  ref_debt_ctr #(.DEBT_MAX(DEBT_MAX)) u_debt (
    .clk(clk), .rst_n(rst_n), .add(tick), .take(take), .owed_nz(owed_nz)
  );

  ref_cycle_fsm #(
    .PAUSE_CYC(PAUSE_CYC), .INIT_CYCLES(INIT_CYCLES), .CSR_CYC(CSR_CYC),
    .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .owed_nz(owed_nz), .gnt(ref_gnt), .take(take),
    .req(ref_req), .done(ref_done), .owner(ref_owner), .ready(ready),
    .pins_n(ref_pins_n)
  );

  always_comb begin
    mc_pins_n          = '1;
    mc_pins_n[PIN_RAS] = mc_ras_n;
    mc_pins_n[PIN_CAS] = mc_cas_n;
    mc_pins_n[PIN_WE]  = mc_we_n;
  end

  ref_pin_mux #(.N(NPINS)) u_mux (
    .sel_ref(ref_owner), .ref_n(ref_pins_n), .mc_n(mc_pins_n), .out_n(out_pins_n)
  );

  assign dram_ras_n = out_pins_n[PIN_RAS];
  assign dram_cas_n = out_pins_n[PIN_CAS];
  assign dram_we_n  = out_pins_n[PIN_WE];
endmodule

// File: rtl/ref_sched_chk.sv
module ref_sched_chk #(
  parameter int RAS_CYC = 6,
  parameter int RP_CYC  = 4
) (
  input logic clk,
  input logic rst_n,
  input logic ref_gnt,
  input logic ref_req,
  input logic ref_done,
  input logic ref_owner,
  input logic ready,
  input logic dram_ras_n,
  input logic dram_cas_n,
  input logic dram_we_n
);
  localparam int LW = $clog2(RAS_CYC + 2) + 1;
  localparam int HW = $clog2(RP_CYC + 1) + 1;

  logic [LW-1:0] lo_cnt;
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
    end else begin
      if (ref_owner && !dram_ras_n) begin
        if (lo_cnt != LW'(RAS_CYC + 1)) lo_cnt <= lo_cnt + 1'b1;
      end else lo_cnt <= '0;
      if (ref_owner && dram_ras_n) begin
        if (hi_cnt != HW'(RP_CYC)) hi_cnt <= hi_cnt + 1'b1;
      end else hi_cnt <= '0;
    end
  end

  // R5
  we_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_owner |-> dram_we_n);

  // R3
  cas_leads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_owner && $past(ref_owner) && $fell(dram_ras_n)) |-> $past(!dram_cas_n));

  // R3
  cas_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_owner && !dram_ras_n) |-> !dram_cas_n);

  // R4
  ras_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_owner && $past(ref_owner) && $rose(dram_ras_n)) |-> (lo_cnt == LW'(RAS_CYC)));

  // R4
  precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_owner && $past(ref_owner) && $fell(dram_ras_n)) |-> (hi_cnt == HW'(RP_CYC)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |=> !ref_done);

  // R10
  done_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_done |-> !ref_owner);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && !ref_gnt) |=> ref_req);

  // R7
  grant_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req && ref_gnt) |=> (ref_owner && !ref_req));

  // R2
  no_req_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> !ref_req);
endmodule

bind cbr_refresh_sched ref_sched_chk #(.RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
  .ref_done(ref_done), .ref_owner(ref_owner), .ready(ready),
  .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n)
);

// File: tb/sim_cbr_refresh_sched.sv
module sim_cbr_refresh_sched;
  localparam int P    = 300;
  localparam int INIT = 8;
  localparam int I    = 200;
  localparam int CSR  = 2;
  localparam int RASW = 6;
  localparam int RP   = 4;
  localparam int DMAX = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, ref_gnt;
  logic mc_ras_n, mc_cas_n, mc_we_n;
  logic ref_req, ref_done, ref_owner, ready, dram_ras_n, dram_cas_n, dram_we_n;

  cbr_refresh_sched #(
    .PAUSE_CYC(P), .INIT_CYCLES(INIT), .INTERVAL_CYC(I), .CSR_CYC(CSR),
    .RAS_CYC(RASW), .RP_CYC(RP), .DEBT_MAX(DMAX)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .mc_ras_n(mc_ras_n), .mc_cas_n(mc_cas_n),
    .mc_we_n(mc_we_n), .ref_gnt(ref_gnt), .ref_req(ref_req), .ref_done(ref_done),
    .ref_owner(ref_owner), .ready(ready), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n)
  );

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // controller strobes keep changing so the multiplexer is exercised (R11)
  logic [2:0] mc_pat = 3'd0;
  always @(negedge clk) begin
    mc_pat <= mc_pat + 3'd1;
    {mc_we_n, mc_cas_n, mc_ras_n} <= mc_pat;
  end

  // monitor / scoreboard
  int  n_rst = 0, n_rdy = 0, init_falls = 0, burst_falls = 0;
  int  hi_cnt = 0, lo_cnt = 0, csr_cnt = 0;
  bit  cas_seen = 1'b0, rdy_seen = 1'b0, req_seen = 1'b0;
  logic p_ras = 1'b1, p_req = 1'b0, p_gnt = 1'b0, p_done = 1'b0, p_own = 1'b0, p_rdy = 1'b0;

  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      n_rst++;
      if (rdy_seen) n_rdy++;
      if (!cas_seen && !dram_cas_n) begin
        cas_seen = 1'b1;
        chk(n_rst == P, "R1 first CAS fall cycle", n_rst, P);
      end
      if (!cas_seen)
        chk(ref_owner && dram_ras_n && dram_cas_n && dram_we_n, "R1 pins high in pause",
            {ref_owner, dram_ras_n, dram_cas_n, dram_we_n}, 15);
      if (ref_owner) chk(dram_we_n === 1'b1, "R5 WE high while owned", dram_we_n, 1);
      if (!ref_owner)
        chk({dram_we_n, dram_cas_n, dram_ras_n} === {mc_we_n, mc_cas_n, mc_ras_n},
            "R11 pins follow controller", {dram_we_n, dram_cas_n, dram_ras_n},
            {mc_we_n, mc_cas_n, mc_ras_n});
      if (!ready) chk(!ref_req, "R2 no request during init", ref_req, 0);
      if (ref_owner && p_own && p_ras && !dram_ras_n) begin
        chk(csr_cnt == CSR, "R3 CAS lead before RAS fall", csr_cnt, CSR);
        if (ready) begin
          burst_falls++;
          chk(hi_cnt == RP + CSR, "R12 R4 high time before RAS fall", hi_cnt, RP + CSR);
        end else init_falls++;
      end
      if (ref_owner && p_own && !p_ras && dram_ras_n)
        chk(lo_cnt == RASW, "R4 RAS low width", lo_cnt, RASW);
      if (ref_owner && !dram_ras_n) chk(!dram_cas_n, "R3 CAS held during RAS low", dram_cas_n, 0);
      if (ready && !p_rdy) begin
        chk(init_falls == INIT, "R2 init refresh count", init_falls, INIT);
        rdy_seen = 1'b1;
        n_rdy = 0;
      end
      if (ref_req && !p_req) begin
        if (!req_seen) chk(n_rdy == I + 1, "R6 first request delay", n_rdy, I + 1);
        chk((n_rdy - 1) % I == 0, "R6 request on interval", n_rdy, ((n_rdy - 1) / I) * I + 1);
        req_seen = 1'b1;
      end
      if (p_req && !p_gnt) chk(ref_req, "R7 request held", ref_req, 1);
      if (p_req && p_gnt) chk(ref_owner && !ref_req, "R7 takeover", {ref_owner, ref_req}, 2);
      if (ref_done) begin
        chk(!ref_owner, "R10 pins released at done", ref_owner, 0);
        chk(hi_cnt == RP, "R4 final precharge", hi_cnt, RP);
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected done", burst_falls, -1);
        else begin
          int e;
          e = exp_q.pop_front();
          chk(burst_falls == e, "R8 R9 refreshes per grant", burst_falls, e);
        end
        burst_falls = 0;
      end
      if (p_done) chk(!ref_done, "R10 done one cycle", ref_done, 0);
      hi_cnt  = (ref_owner && dram_ras_n) ? hi_cnt + 1 : 0;
      lo_cnt  = (ref_owner && !dram_ras_n) ? lo_cnt + 1 : 0;
      csr_cnt = (ref_owner && !dram_cas_n) ? (dram_ras_n ? csr_cnt + 1 : csr_cnt) : 0;
      p_ras = dram_ras_n; p_req = ref_req; p_gnt = ref_gnt;
      p_done = ref_done; p_own = ref_owner; p_rdy = ready;
    end
  end

  task automatic serve(input int delay, input int expect_n);
    do @(negedge clk); while (!ref_req);
    exp_q.push_back(expect_n);
    repeat (delay) @(negedge clk);
    ref_gnt = 1'b1;
    @(negedge clk);
    ref_gnt = 1'b0;
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    rst_n = 1'b0;
    ref_gnt = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ref_owner && dram_ras_n && dram_cas_n && dram_we_n && !ready && !ref_req && !ref_done,
        "R1 reset state", {ref_owner, dram_ras_n, dram_cas_n, dram_we_n, ready, ref_req, ref_done},
        7'b1111000);
    #1 rst_n = 1'b1;
    do @(negedge clk); while (!ready);
    serve(0, 1);               // R8 single owed refresh
    serve(0, 1);
    serve(2 * I + 20, 3);      // R8 three owed, served back to back
    serve(9 * I + 20, DMAX);   // R9 ten opportunities, capped at DMAX
    serve(0, 1);
    for (int k = 0; k < 2 * I && exp_q.size() != 0; k++) @(negedge clk);
    chk(exp_q.size() == 0, "R8 all grants completed", exp_q.size(), 0);
    repeat (20) @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 200000, 0);
      summary();
      $finish;
    end
  end
endmodule